// File: doc/BRIEF.md
# Alarm Comparator and Status Flag Unit

This block keeps a 24-bit alarm value packed the same way as the live calendar counter. It compares the two once per minute. A minute-edge strobe arms a delay counter that counts timebase ticks. When the configured tick count runs out, the alarm and the time are compared, and an equal result latches a match flag. The match flag stays set until the host clears it, and it is also driven on a dedicated pin.

A no-date mode flag limits the comparison to hours and minutes. The host sets and clears this flag with separate commands.

A power-fail flag latches a failure indication from one of several sources, chosen by two mode pins. Only an execute-type write clears it. The host bus decoder outside this block turns bus traffic into the single-cycle command strobes used here.

Top module: `alarm_flag_unit`

## Requirements
- R1: After reset, matchFlag, noDateFlag and powFailFlag are all 0.
- R2: A cycle with alarmWrEn high loads alarmWrData into the alarm value. All later comparisons use the new value.
- R3: The comparison happens on the DELAY_TICKS-th tick (default 131) after minuteEdge. A match shows on matchFlag in the cycle after that tick, and never on an earlier tick.
- R4: With noDateFlag at 0, all 24 bits take part in the comparison. The packed layout is month [23:19], day [18:13], hour [12:7] and minute [6:0]. A difference in any bit prevents a match.
- R5: With noDateFlag at 1, only bits [12:0] (hour and minute) are compared. Differences in bits [23:13] are ignored.
- R6: setNoDateCmd sets noDateFlag and clrNoDateCmd clears it. If both are high in the same cycle, set wins.
- R7: matchFlag stays at 1 until clrMatchCmd. A clear in the same cycle as a match event leaves the flag set. A clear in the next cycle clears it.
- R8: Each minuteEdge gives at most one comparison. After that comparison, further ticks do not set matchFlag, even when the time later equals the alarm.
- R9: A minuteEdge that arrives while the delay is still running restarts the full DELAY_TICKS count.
- R10: The power-fail source is chosen by {extSel, pfPin}. 00 selects intPfDetect. 01 is test mode and selects testPf. 10 is external mode, and pfPin low signals a failure. 11 senses no failure. A sensed failure sets powFailFlag in the next cycle.
- R11: powFailFlag stays set after the failure ends, until execWrite clears it. A failure in the same cycle as execWrite leaves it set.
- R12: matchPin always carries the value of matchFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| alarmWrEn | input | 1 | Load strobe for the alarm value |
| alarmWrData | input | 24 | New alarm value |
| setNoDateCmd | input | 1 | Host command: set no-date mode |
| clrNoDateCmd | input | 1 | Host command: clear no-date mode |
| clrMatchCmd | input | 1 | Host command: clear the match flag |
| execWrite | input | 1 | Execute-type write; clears power-fail |
| minuteEdge | input | 1 | One-cycle strobe at the minute boundary |
| tick | input | 1 | One-cycle timebase tick |
| timeNow | input | 24 | Live calendar counter value |
| extSel | input | 1 | Power-fail mode select, upper bit |
| pfPin | input | 1 | Power-fail pin: lower mode bit, and the failure input in external mode |
| intPfDetect | input | 1 | Internal supply detector, high on failure |
| testPf | input | 1 | Test-mode failure input |
| matchFlag | output | 1 | Latched alarm match |
| noDateFlag | output | 1 | No-date comparison mode |
| powFailFlag | output | 1 | Latched power failure |
| matchPin | output | 1 | Pin copy of matchFlag |

## Verification
Two pairs of events can land in the same cycle. The first is the compare-and-set on the final delay tick together with a host clear of the match flag. The second is a sensed power failure together with an execute write. The bench raises both strobes on the same clock edge and expects the flag to be set afterwards. In the cycle after that, it issues the clear alone and expects the flag to drop. The no-date set and clear commands are also raised together, and set must win.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int TIME_W = 24;
  localparam int HM_W   = 13;   // hour and minute fields at the bottom

  typedef struct packed {
    logic sampleNow;
    logic loadAlarm;
    logic clrMatch;
    logic setNoDate;
    logic clrNoDate;
    logic clrPowFail;
  } ctrlStrobes_t;
endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int DELAY_TICKS = 131
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         minuteEdge,
  input  logic         tick,
  input  logic         alarmWrEn,
  input  logic         setNoDateCmd,
  input  logic         clrNoDateCmd,
  input  logic         clrMatchCmd,
  input  logic         execWrite,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = $clog2(DELAY_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_TICKS);

  logic [CNT_W-1:0] ticksLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ticksLeft <= '0;
    end else if (minuteEdge) begin
      ticksLeft <= CNT_LOAD;
    end else if (tick && ticksLeft != '0) begin
      ticksLeft <= ticksLeft - 1'b1;
    end
  end

  always_comb begin
    strobes.sampleNow  = tick && !minuteEdge && (ticksLeft == CNT_W'(1));
    strobes.loadAlarm  = alarmWrEn;
    strobes.clrMatch   = clrMatchCmd;
    strobes.setNoDate  = setNoDateCmd;
    strobes.clrNoDate  = clrNoDateCmd;
    strobes.clrPowFail = execWrite;
  end
endmodule

// File: rtl/alarm_dp.sv
module alarm_dp
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [TIME_W-1:0] alarmWrData,
  input  logic [TIME_W-1:0] timeNow,
  input  logic              extSel,
  input  logic              pfPin,
  input  logic              intPfDetect,
  input  logic              testPf,
  output logic              matchFlag,
  output logic              noDateFlag,
  output logic              powFailFlag
);
  localparam logic [TIME_W-1:0] HM_MASK = TIME_W'((1 << HM_W) - 1);

  logic [TIME_W-1:0] alarmReg;
  logic [TIME_W-1:0] cmpMask;
  logic              fieldsEqual;
  logic              failSensed;

  assign cmpMask     = noDateFlag ? HM_MASK : '1;
  assign fieldsEqual = ((alarmReg ^ timeNow) & cmpMask) == '0;

  always_comb begin
    unique case ({extSel, pfPin})
      2'b00:   failSensed = intPfDetect;
      2'b01:   failSensed = testPf;
      2'b10:   failSensed = 1'b1;
      default: failSensed = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmReg    <= '0;
      matchFlag   <= 1'b0;
      noDateFlag  <= 1'b0;
      powFailFlag <= 1'b0;
    end else begin
      if (strobes.loadAlarm) alarmReg <= alarmWrData;
      matchFlag   <= (strobes.sampleNow && fieldsEqual) || (matchFlag && !strobes.clrMatch);
      noDateFlag  <= strobes.setNoDate || (noDateFlag && !strobes.clrNoDate);
      powFailFlag <= failSensed || (powFailFlag && !strobes.clrPowFail);
    end
  end
endmodule

// File: rtl/alarm_flag_unit.sv
module alarm_flag_unit
  import alarm_pkg::*;
#(
  parameter int DELAY_TICKS = 131
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        alarmWrEn,
  input  logic [23:0] alarmWrData,
  input  logic        setNoDateCmd,
  input  logic        clrNoDateCmd,
  input  logic        clrMatchCmd,
  input  logic        execWrite,
  input  logic        minuteEdge,
  input  logic        tick,
  input  logic [23:0] timeNow,
  input  logic        extSel,
  input  logic        pfPin,
  input  logic        intPfDetect,
  input  logic        testPf,
  output logic        matchFlag,
  output logic        noDateFlag,
  output logic        powFailFlag,
  output logic        matchPin
);
  ctrlStrobes_t strobes;

  alarm_ctrl #(.DELAY_TICKS(DELAY_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .minuteEdge(minuteEdge), .tick(tick),
    .alarmWrEn(alarmWrEn), .setNoDateCmd(setNoDateCmd), .clrNoDateCmd(clrNoDateCmd),
    .clrMatchCmd(clrMatchCmd), .execWrite(execWrite), .strobes(strobes)
  );

  alarm_dp uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .alarmWrData(alarmWrData),
    .timeNow(timeNow), .extSel(extSel), .pfPin(pfPin), .intPfDetect(intPfDetect),
    .testPf(testPf), .matchFlag(matchFlag), .noDateFlag(noDateFlag),
    .powFailFlag(powFailFlag)
  );

  assign matchPin = matchFlag;
endmodule

// File: rtl/alarm_flag_unit_chk.sv
module alarm_flag_unit_chk (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic clrMatchCmd,
  input logic setNoDateCmd,
  input logic execWrite,
  input logic extSel,
  input logic pfPin,
  input logic matchFlag,
  input logic noDateFlag,
  input logic powFailFlag
);
  // R3
  match_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> $past(tick));
  // R7
  match_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !clrMatchCmd) |=> matchFlag);
  // R7
  match_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrMatchCmd && !tick) |=> !matchFlag);
  // R6
  nodate_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    setNoDateCmd |=> noDateFlag);
  // R10
  ext_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extSel && !pfPin) |=> powFailFlag);
  // R11
  powfail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powFailFlag && !execWrite) |=> powFailFlag);
endmodule

bind alarm_flag_unit alarm_flag_unit_chk uChk (
  .clk(clk), .rstN(rstN), .tick(tick), .clrMatchCmd(clrMatchCmd),
  .setNoDateCmd(setNoDateCmd), .execWrite(execWrite), .extSel(extSel),
  .pfPin(pfPin), .matchFlag(matchFlag), .noDateFlag(noDateFlag),
  .powFailFlag(powFailFlag)
);

// File: tb/tb_alarm_flag_unit.sv
module tb_alarm_flag_unit;
  localparam int DELAY = 131;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic alarmWrEn = 0, setNoDateCmd = 0, clrNoDateCmd = 0, clrMatchCmd = 0, execWrite = 0;
  logic minuteEdge = 0, tick = 0;
  logic [23:0] alarmWrData = '0, timeNow = '0;
  logic extSel = 1, pfPin = 1, intPfDetect = 0, testPf = 0;
  logic matchFlag, noDateFlag, powFailFlag, matchPin;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  alarm_flag_unit #(.DELAY_TICKS(DELAY)) dut (.*);

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; cyc(); tick = 0; cyc();
    end
  endtask

  task automatic minute();
    minuteEdge = 1; cyc(); minuteEdge = 0; cyc();
  endtask

  task automatic clrMatch();
    clrMatchCmd = 1; cyc(); clrMatchCmd = 0; cyc();
  endtask

  task automatic loadAlarm(input logic [23:0] v);
    alarmWrData = v; alarmWrEn = 1; cyc(); alarmWrEn = 0; cyc();
  endtask

  task automatic clrPf();
    extSel = 1; pfPin = 1; execWrite = 1; cyc(); execWrite = 0; cyc();
  endtask

  task automatic pfCase(input logic e, input logic p, input logic ip, input logic tp,
                        input logic exp, input string tag);
    clrPf();
    intPfDetect = ip; testPf = tp; extSel = e; pfPin = p; cyc();
    check(powFailFlag, exp, tag);
    extSel = 1; pfPin = 1; intPfDetect = 0; testPf = 0;
  endtask

  initial begin
    logic [23:0] alarmVal;
    alarmVal = 24'h9A5C3B;
    repeat (3) cyc();
    rstN = 1; cyc();
    // R1 reset state
    check(matchFlag, 0, "R1 match");
    check(noDateFlag, 0, "R1 nodate");
    check(powFailFlag, 0, "R1 powfail");

    // R2 / R3: load alarm and time equal, check timing
    loadAlarm(alarmVal);
    timeNow = alarmVal;
    minute();
    ticks(DELAY - 1);
    check(matchFlag, 0, "R3 early");
    ticks(1);
    check(matchFlag, 1, "R3 on time");
    check(matchPin, 1, "R12 pin set");
    clrMatch();
    check(matchFlag, 0, "R7 clear");
    check(matchPin, 0, "R12 pin clear");

    // R4/R5 sweep of each bit in both compare modes
    for (int m = 0; m < 2; m++) begin
      if (m == 1) begin
        setNoDateCmd = 1; cyc(); setNoDateCmd = 0; cyc();
        check(noDateFlag, 1, "R6 set");
      end
      for (int b = 0; b < 24; b++) begin
        timeNow = alarmVal ^ (24'd1 << b);
        minute(); ticks(DELAY);
        check(matchFlag, (m == 1 && b >= 13) ? 1'b1 : 1'b0, m == 1 ? "R5 masked bit" : "R4 full bit");
        clrMatch();
      end
    end

    // R6 simultaneous set/clear, then clear
    setNoDateCmd = 1; clrNoDateCmd = 1; cyc(); setNoDateCmd = 0; clrNoDateCmd = 0; cyc();
    check(noDateFlag, 1, "R6 set wins");
    clrNoDateCmd = 1; cyc(); clrNoDateCmd = 0; cyc();
    check(noDateFlag, 0, "R6 clear");

    // R2 new alarm value is used
    loadAlarm(alarmVal ^ 24'h000100);
    timeNow = alarmVal;
    minute(); ticks(DELAY);
    check(matchFlag, 0, "R2 old value gone");
    timeNow = alarmVal ^ 24'h000100;
    minute(); ticks(DELAY);
    check(matchFlag, 1, "R2 new value");
    clrMatch();

    // R8: one comparison per minute edge
    timeNow = 24'h0;
    minute(); ticks(DELAY);
    check(matchFlag, 0, "R8 mismatch");
    timeNow = alarmVal ^ 24'h000100;
    ticks(20);
    check(matchFlag, 0, "R8 no resample");

    // R9: restart
    minute(); ticks(100);
    minute(); ticks(DELAY - 1);
    check(matchFlag, 0, "R9 restart early");
    ticks(1);
    check(matchFlag, 1, "R9 restart on time");
    clrMatch();

    // R7: clear coinciding with set, then immediate clear
    minute(); ticks(DELAY - 1);
    tick = 1; clrMatchCmd = 1; cyc(); tick = 0; clrMatchCmd = 0;
    check(matchFlag, 1, "R7 set wins");
    clrMatchCmd = 1; cyc(); clrMatchCmd = 0;
    check(matchFlag, 0, "R7 immediate clear");
    cyc();
    check(matchFlag, 0, "R7 stays clear");

    // R10 source table
    pfCase(0, 0, 1, 0, 1, "R10 internal fail");
    pfCase(0, 0, 0, 1, 0, "R10 internal ok");
    pfCase(0, 1, 0, 1, 1, "R10 test fail");
    pfCase(0, 1, 1, 0, 0, "R10 test ok");
    pfCase(1, 0, 0, 0, 1, "R10 external fail");
    pfCase(1, 1, 1, 1, 0, "R10 none sensed");

    // R11 latch and clear
    clrPf();
    extSel = 1; pfPin = 0; cyc(); pfPin = 1; cyc(); cyc();
    check(powFailFlag, 1, "R11 latched");
    execWrite = 1; pfPin = 0; cyc(); execWrite = 0; pfPin = 1; cyc();
    check(powFailFlag, 1, "R11 set wins");
    clrPf();
    check(powFailFlag, 0, "R11 cleared");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule